// File: doc/BRIEF.md
# Folded Three-Level Wavelet Decomposer

This block performs a streaming one-dimensional discrete wavelet transform over three dyadic levels. Signed 12-bit samples enter on a valid/ready stream at up to one per clock. Every level filters with a 4-tap lowpass/highpass pair and keeps every second result. The first level has its own filter pair. A single shared second pair serves both level two and level three, and the two levels take turns on it according to where the current sample falls in an eight-sample frame.

Every eight accepted inputs produce exactly eight coefficients: four level-one details, two level-two details, one level-three detail and one final scaling coefficient. Each accepted input therefore yields exactly one output word, tagged with its level. Back-pressure rules: an output word is held unchanged while `res_valid` is high and `res_ready` is low. During that time `smp_ready` is low, so no new sample is taken. When the output register is empty, or is being drained in the same cycle, `smp_ready` is high.

A synchronous reset clears every delay register and the frame position. The transform after reset therefore behaves as if the signal were preceded by zeros.

Top module: `dwt3_fold`

## Requirements
- R1: During and directly after reset, `res_valid` is 0 and `smp_ready` is 1.
- R2: Each accepted input sample makes exactly one output word, and the output words leave in the order the inputs were accepted.
- R3: Accepted inputs are numbered n = 0, 1, 2, … from reset, with frame position p = n mod 8. For odd p the output carries level tag 1 and the level-one detail d1[(n-1)/2]. Here d1[m] = HP(x[2m+1], x[2m], x[2m-1], x[2m-2]), the newest sample comes first, and x with a negative index is 0.
- R4: The level-two detail d2[k] = HP over a1[2k+1..2k-2] is emitted with tag 2: d2[2f-1] at p = 0 and d2[2f] at p = 4, where f = n div 8. The lowpass a1[m] uses the same window as d1[m], and a1 with a negative index is 0.
- R5: At p = 2 the output is tag 3 with the level-three detail d3[f-1]. At p = 6 it is tag 0 with the final scaling a3[f-1]. Both are filtered over a2[2q+1..2q-2], where a2 is the lowpass of the R4 window, and any negative index gives 0.
- R6: Lowpass taps, newest first, are 495, 857, 230, -133 in Q1.10. Highpass taps are -133, -230, 857, -495. Each result is (sum + 512) arithmetically shifted right by 10, then saturated to the range -2048..2047.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_coef` and `res_level` hold their values and `smp_ready` is 0.
- R8: A reset in the middle of a frame restarts numbering at n = 0 and clears all filter history, so the outputs that follow match a run from a zero start.
- R9: The level tags repeat the order 2, 1, 3, 1, 2, 1, 0, 1 over each frame of eight accepted inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Input sample present |
| smp_ready | output | 1 | Block can take a sample this cycle |
| smp_data | input | 12 | Signed input sample |
| res_valid | output | 1 | Output word present |
| res_ready | input | 1 | Consumer takes the output word |
| res_coef | output | 12 | Signed coefficient |
| res_level | output | 2 | 1..3 detail level, 0 final scaling |

## Verification
The hardest case to reach from the ports is the shared stage's history at the edge of the zero start. Level-three outputs only carry signal once several frames have passed, and a reset in the middle of a frame must clear the level-two history that feeds them. The stimulus places an impulse at each of the eight frame positions, which moves energy through every slot of the shared schedule. Runs that stop at frame position five are followed by a reset and a fresh run. Random stalls on both sides of the stream check that the schedule is tied to accepted samples and not to clock cycles.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  typedef enum logic [1:0] {
    LVL_SCALE = 2'd0,
    LVL_D1    = 2'd1,
    LVL_D2    = 2'd2,
    LVL_D3    = 2'd3
  } lvl_e;

  localparam int FRAME_LEN = 8;
endpackage

// File: rtl/dwt_fir4.sv
module dwt_fir4 #(
  parameter int W = 12,
  parameter int CW = 12,
  parameter int FRAC = 10,
  parameter int TAPS = 4,
  parameter logic [TAPS*CW-1:0] COEF = '0
) (
  input  logic [TAPS*W-1:0] win,
  output logic [W-1:0]      y
);
  localparam int AW = W + CW + $clog2(TAPS) + 1;
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (W-1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);
  localparam logic signed [AW-1:0] HALF = AW'(64'sd1 <<< (FRAC-1));

  logic signed [AW-1:0] acc, rnd, shr;

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc = acc + AW'($signed(win[i*W +: W])) * AW'($signed(COEF[i*CW +: CW]));
    end
    rnd = acc + HALF;
    shr = rnd >>> FRAC;
    if (shr > MAXV)      y = MAXV[W-1:0];
    else if (shr < MINV) y = MINV[W-1:0];
    else                 y = shr[W-1:0];
  end
endmodule

// File: rtl/dwt_qmf_pair.sv
module dwt_qmf_pair #(
  parameter int W = 12,
  parameter int CW = 12,
  parameter int FRAC = 10,
  parameter int TAPS = 4,
  parameter logic [TAPS*CW-1:0] LP_COEF = '0
) (
  input  logic [TAPS*W-1:0] win,
  output logic [W-1:0]      lo,
  output logic [W-1:0]      hi
);
  function automatic logic [TAPS*CW-1:0] mirror(input logic [TAPS*CW-1:0] c);
    logic [TAPS*CW-1:0] r;
    logic [CW-1:0] v;
    r = '0;
    for (int i = 0; i < TAPS; i++) begin
      v = c[(TAPS-1-i)*CW +: CW];
      if (i % 2 == 1) v = -v;
      r[i*CW +: CW] = v;
    end
    return r;
  endfunction

  localparam logic [TAPS*CW-1:0] HP_COEF = mirror(LP_COEF);

  logic [W-1:0] y [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [TAPS*CW-1:0] C = (b == 0) ? LP_COEF : HP_COEF;
    dwt_fir4 #(.W(W), .CW(CW), .FRAC(FRAC), .TAPS(TAPS), .COEF(C)) u_fir (
      .win(win),
      .y  (y[b])
    );
  end

  assign lo = y[0];
  assign hi = y[1];
endmodule

// File: rtl/dwt_fold_sched.sv
module dwt_fold_sched #(
  parameter int LEVELS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic is_l1,
  output logic is_l2,
  output logic is_l3,
  output logic is_scale
);
  localparam int PW = LEVELS;
  localparam logic [PW-1:0] LAST = '1;

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (step) phase <= phase + 1'b1;
  end

  // Odd slots serve level one; the even slots are shared by the folded stage.
  assign is_l1    = phase[0];
  assign is_l2    = (phase[1:0] == 2'b00);
  assign is_l3    = (phase == PW'(2));
  assign is_scale = (phase == PW'(6));

  // R9: a full frame wraps back to slot zero
  p_frame_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    step && (phase == LAST) |=> (phase == '0));

  // R9: exactly one role per slot
  p_one_role_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({is_l1, is_l2, is_l3, is_scale}) == 1);
endmodule

// File: rtl/dwt3_fold.sv
module dwt3_fold #(
  parameter int W = 12,
  parameter int CW = 12,
  parameter int FRAC = 10,
  parameter int TAPS = 4,
  parameter logic [TAPS*CW-1:0] LP_COEF = {12'hF7B, 12'h0E6, 12'h359, 12'h1EF}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] smp_data,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_coef,
  output logic [1:0]   res_level
);
  import dwt_pkg::*;

  localparam int HIST = TAPS - 1;

  logic [W-1:0] xd  [HIST];
  logic [W-1:0] a1h [TAPS];
  logic [W-1:0] a2h [TAPS];
  logic [W-1:0] scale_hold;

  logic [TAPS*W-1:0] win1, win2;
  logic [W-1:0] l1_lo, l1_hi, s2_lo, s2_hi;
  logic take;
  logic is_l1, is_l2, is_l3, is_scale;

  assign smp_ready = !res_valid || res_ready;
  assign take      = smp_valid && smp_ready;

  dwt_fold_sched #(.LEVELS(3)) u_sched (
    .clk(clk), .rst(rst), .step(take),
    .is_l1(is_l1), .is_l2(is_l2), .is_l3(is_l3), .is_scale(is_scale)
  );

  // Window slot 0 is the newest value.
  always_comb begin
    win1[0 +: W] = smp_data;
    for (int i = 0; i < HIST; i++) win1[(i+1)*W +: W] = xd[i];
    for (int i = 0; i < TAPS; i++) win2[i*W +: W] = is_l3 ? a2h[i] : a1h[i];
  end

  dwt_qmf_pair #(.W(W), .CW(CW), .FRAC(FRAC), .TAPS(TAPS), .LP_COEF(LP_COEF)) u_stage1 (
    .win(win1), .lo(l1_lo), .hi(l1_hi)
  );

  dwt_qmf_pair #(.W(W), .CW(CW), .FRAC(FRAC), .TAPS(TAPS), .LP_COEF(LP_COEF)) u_stage2 (
    .win(win2), .lo(s2_lo), .hi(s2_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST; i++) xd[i] <= '0;
      for (int i = 0; i < TAPS; i++) begin
        a1h[i] <= '0;
        a2h[i] <= '0;
      end
      scale_hold <= '0;
      res_valid  <= 1'b0;
      res_coef   <= '0;
      res_level  <= LVL_SCALE;
    end else if (take) begin
      xd[0] <= smp_data;
      for (int i = 1; i < HIST; i++) xd[i] <= xd[i-1];
      res_valid <= 1'b1;
      if (is_l1) begin
        a1h[0] <= l1_lo;
        for (int i = 1; i < TAPS; i++) a1h[i] <= a1h[i-1];
        res_coef  <= l1_hi;
        res_level <= LVL_D1;
      end else if (is_l2) begin
        a2h[0] <= s2_lo;
        for (int i = 1; i < TAPS; i++) a2h[i] <= a2h[i-1];
        res_coef  <= s2_hi;
        res_level <= LVL_D2;
      end else if (is_l3) begin
        scale_hold <= s2_lo;
        res_coef   <= s2_hi;
        res_level  <= LVL_D3;
      end else begin
        res_coef  <= scale_hold;
        res_level <= LVL_SCALE;
      end
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R1: output register empty right after reset
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid);

  // R2: every accepted sample yields a word
  p_word_per_sample_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> res_valid);

  // R3: odd slots give level-one details
  p_l1_tag_r3: assert property (@(posedge clk) disable iff (rst)
    take && is_l1 |=> res_level == LVL_D1);

  // R4: level-two detail slots
  p_l2_tag_r4: assert property (@(posedge clk) disable iff (rst)
    take && is_l2 |=> res_level == LVL_D2);

  // R5: level-three detail slot
  p_l3_tag_r5: assert property (@(posedge clk) disable iff (rst)
    take && is_l3 |=> res_level == LVL_D3);

  // R7: a stalled word stays put
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_coef) && $stable(res_level));
endmodule

// File: tb/dwt3_fold_bench.sv
module dwt3_fold_bench;
  localparam int W = 12;
  localparam int NMAX = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [W-1:0] smp_data = '0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [W-1:0] res_coef;
  logic [1:0] res_level;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int xs [NMAX];
  int a1 [NMAX/2];
  int d1 [NMAX/2];
  int a2 [NMAX/4];
  int d2 [NMAX/4];
  int a3 [NMAX/8];
  int d3 [NMAX/8];

  always #2.5 clk = ~clk;

  dwt3_fold u_dwt3_fold (
    .clk(clk), .rst(rst),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_coef(res_coef), .res_level(res_level)
  );

  function automatic int rsat(longint acc);
    longint r;
    r = (acc + 512) >>> 10;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  function automatic int lpf(int a, int b, int c, int d);
    return rsat(longint'(495)*a + longint'(857)*b + longint'(230)*c - longint'(133)*d);
  endfunction

  function automatic int hpf(int a, int b, int c, int d);
    return rsat(-longint'(133)*a - longint'(230)*b + longint'(857)*c - longint'(495)*d);
  endfunction

  function automatic int gx(int i);
    return (i < 0) ? 0 : xs[i];
  endfunction
  function automatic int ga1(int i);
    return (i < 0) ? 0 : a1[i];
  endfunction
  function automatic int ga2(int i);
    return (i < 0) ? 0 : a2[i];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_model();
    for (int m = 0; m < NMAX/2; m++) begin
      a1[m] = lpf(gx(2*m+1), gx(2*m), gx(2*m-1), gx(2*m-2));
      d1[m] = hpf(gx(2*m+1), gx(2*m), gx(2*m-1), gx(2*m-2));
    end
    for (int k = 0; k < NMAX/4; k++) begin
      a2[k] = lpf(ga1(2*k+1), ga1(2*k), ga1(2*k-1), ga1(2*k-2));
      d2[k] = hpf(ga1(2*k+1), ga1(2*k), ga1(2*k-1), ga1(2*k-2));
    end
    for (int q = 0; q < NMAX/8; q++) begin
      a3[q] = lpf(ga2(2*q+1), ga2(2*q), ga2(2*q-1), ga2(2*q-2));
      d3[q] = hpf(ga2(2*q+1), ga2(2*q), ga2(2*q-1), ga2(2*q-2));
    end
  endtask

  task automatic expect_word(int j, output int tag, output int val);
    int p, f;
    p = j % 8;
    f = j / 8;
    if (p % 2 == 1)  begin tag = 1; val = d1[(j-1)/2]; end
    else if (p == 0) begin tag = 2; val = (f == 0) ? 0 : d2[2*f-1]; end
    else if (p == 4) begin tag = 2; val = d2[2*f]; end
    else if (p == 2) begin tag = 3; val = (f == 0) ? 0 : d3[f-1]; end
    else             begin tag = 0; val = (f == 0) ? 0 : a3[f-1]; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_valid = 1'b0;
    res_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    check(smp_ready == 1'b1, "R1 smp_ready after reset", int'(smp_ready), 1);
  endtask

  // pat: 0 impulse at pos, 1 step, 2 ramp, 3 alternating extremes, 4 random, 5 full-scale constant
  task automatic do_run(int pat, int pos, int n, bit stall, bit after_mid);
    int ni, no, et, ev;
    bit prev_stall;
    logic [W-1:0] sv_coef;
    logic [1:0] sv_lvl;
    string req;
    for (int i = 0; i < NMAX; i++) begin
      case (pat)
        0: xs[i] = (i == pos) ? 1000 : 0;
        1: xs[i] = 700;
        2: xs[i] = i * 37 - 1100;
        3: xs[i] = (i % 2 == 1) ? 2047 : -2048;
        4: xs[i] = int'($urandom_range(0, 4095)) - 2048;
        default: xs[i] = 2047;
      endcase
      if (i >= n) xs[i] = 0;
    end
    build_model();
    do_reset();
    ni = 0;
    no = 0;
    prev_stall = 1'b0;
    sv_coef = '0;
    sv_lvl = '0;
    while (no < n) begin
      @(negedge clk);
      smp_valid = (ni < n) && (!stall || ($urandom_range(0, 3) != 0));
      smp_data  = (ni < n) ? W'(xs[ni]) : '0;
      res_ready = !stall || ($urandom_range(0, 2) != 0);
      #1;
      if (prev_stall) begin
        check(res_valid && res_coef == sv_coef && res_level == sv_lvl,
              "R7 stalled word held", int'($signed(res_coef)), int'($signed(sv_coef)));
      end
      if (res_valid && !res_ready)
        check(smp_ready == 1'b0, "R7 no intake while stalled", int'(smp_ready), 0);
      if (smp_valid && smp_ready) ni++;
      if (res_valid && res_ready) begin
        expect_word(no, et, ev);
        check(int'(res_level) == et, "R9 level tag order", int'(res_level), et);
        if (pat == 3 || pat == 5) req = "R6 saturated value";
        else if (et == 1) req = "R3 level-one detail";
        else if (et == 2) req = "R4 level-two detail";
        else req = "R5 level-three/scaling";
        check(int'($signed(res_coef)) == ev, req, int'($signed(res_coef)), ev);
        if (after_mid && no == 0)
          check(res_level == 2'd2 && res_coef == '0, "R8 zero restart first word",
                int'($signed(res_coef)), 0);
        no++;
      end
      prev_stall = res_valid && !res_ready;
      sv_coef = res_coef;
      sv_lvl = res_level;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    #1;
    check(res_valid == 1'b0 && ni == n, "R2 one word per sample", no, n);
  endtask

  initial begin
    for (int p = 0; p < 8; p++) do_run(0, p + 8, 64, 1'b0, 1'b0);
    do_run(1, 0, 64, 1'b0, 1'b0);
    do_run(2, 0, 64, 1'b1, 1'b0);
    do_run(3, 0, 64, 1'b0, 1'b0);
    do_run(5, 0, 64, 1'b1, 1'b0);
    do_run(4, 0, 13, 1'b1, 1'b0);
    do_run(4, 0, 64, 1'b1, 1'b1);
    do_run(4, 0, 64, 1'b0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule